// File: doc/BRIEF.md
# Snooping Cache Bus-Side Responder

This block sits beside one write-back cache and watches every transaction on a shared, snooped system bus. For each transaction that needs a probe, it looks up the tag and state store in the transaction's first bus cycle. It registers a hit/dirty decision at the close of the second bus cycle and acts in the third. Another agent's write that hits the cache either refreshes the cached line with the bus data or drops the line, as chosen by a static configuration input. Another agent's read or exchange that hits a dirty line makes the block ask the cache to supply the data. For that one transaction this takes the place of the memory module's stale copy.

When a snooped write refreshes a cached line, the block drives the bus SHARED line for the rest of that transaction. The line's own state bits are left untouched. A transaction's length is fixed by its command, and a start that arrives while a transaction is still running is not acted on. The cache data array and bus arbitration are outside the block. The tag store is external, with a one-cycle read latency.

Top module: `snoop_responder`

## Requirements
- R1: Command code on `snp_cmd`: 00 no-op, 01 read, 10 write, 11 exchange. A transaction starts in the cycle where `snp_start` is high while the block is idle (index 0). A write lasts 6 bus cycles and every other command lasts 7, so the next start is accepted at index 6 or 7.
- R2: In the start cycle of a read, write or exchange, `tag_rd_en` is high and `tag_rd_idx` equals address bits [10:5]. The store answers one cycle later. A hit means the valid bit is set and the returned tag equals address bits [31:11].
- R3: The hit/dirty decision is registered at the end of bus cycle index 1, and every resulting action appears in bus cycle index 2.
- R4: A read or exchange that hits a dirty line raises `supply_req` for exactly one cycle at index 2, with `supply_idx` set to the line's set index.
- R5: A miss, or a clean hit on a read or exchange, raises no supply request, no tag write and no line update.
- R6: A write hit with update mode (`cfg_wr_update`=1) raises `line_upd_en` for one cycle at index 2, carrying the bus address and the write data of the start cycle. No tag write is issued, so the line's SHARED and dirty bits keep their previous values.
- R7: On an updating write hit, `bus_shared` is high from index 2 through the last bus cycle of the transaction (4 cycles), and low at all other times.
- R8: A write hit in invalidate mode raises `tag_wr_en` for one cycle at index 2, with `tag_wr_valid`, `tag_wr_dirty` and `tag_wr_shared` all 0, and `bus_shared` stays low.
- R9: The update/invalidate choice is taken from `cfg_wr_update` in the start cycle. Later changes within the transaction have no effect.
- R10: A no-op issues no probe and produces no action.
- R11: A `snp_start` that arrives while a transaction is running issues no probe and produces no action.
- R12: After reset, `tag_rd_en`, `tag_wr_en`, `line_upd_en`, `supply_req` and `bus_shared` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_start | input | 1 | First bus cycle of a snooped transaction |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | 32 | Snooped byte address |
| snp_wdata | input | 64 | Snooped write data |
| cfg_wr_update | input | 1 | 1 = update on write hit, 0 = invalidate |
| tag_rd_en | output | 1 | Tag store read strobe |
| tag_rd_idx | output | 6 | Tag store read set index |
| tag_rd_tag | input | 21 | Stored tag, one cycle after the strobe |
| tag_rd_valid | input | 1 | Stored valid bit |
| tag_rd_dirty | input | 1 | Stored dirty bit |
| tag_wr_en | output | 1 | Tag store write strobe |
| tag_wr_idx | output | 6 | Tag store write set index |
| tag_wr_valid | output | 1 | New valid bit |
| tag_wr_dirty | output | 1 | New dirty bit |
| tag_wr_shared | output | 1 | New shared bit |
| line_upd_en | output | 1 | Request to overwrite cached data |
| line_upd_addr | output | 32 | Address of the update |
| line_upd_data | output | 64 | Data of the update |
| supply_req | output | 1 | Request that the cache drive the line onto the bus |
| supply_idx | output | 6 | Set index of the line to supply |
| bus_shared | output | 1 | Bus SHARED line drive |

## Verification
The line-update request and the first cycle of SHARED fall into the same cycle, index 2 of an updating write hit. The bench counts SHARED cycles per transaction and records the cycle index of each request, so a skew between the two shows up as a wrong index or a wrong count. A second collision happens when transactions run back-to-back. SHARED must drop in the very cycle in which the next transaction's probe is issued, so the bench runs transactions with no gap and checks for SHARED outside any open window. A stray start during a running write is also driven, and must leave the probe count and the actions unchanged.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_XCHG  = 2'b11
  } snp_cmd_e;

  localparam int unsigned WRITE_CYCLES_DEF = 6;
  localparam int unsigned OTHER_CYCLES_DEF = 7;

  function automatic logic needs_probe(snp_cmd_e c);
    return c != CMD_NOP;
  endfunction

  function automatic logic may_supply(snp_cmd_e c);
    return (c == CMD_READ) || (c == CMD_XCHG);
  endfunction

endpackage

// File: rtl/snoop_seq.sv
module snoop_seq
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned WR_CYC   = WRITE_CYCLES_DEF,
  parameter int unsigned OT_CYC   = OTHER_CYCLES_DEF,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  snp_cmd_e          cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cfg_upd,
  output logic              accept,
  output logic              busy,
  output logic [CNT_W-1:0]  phase,
  output logic              last,
  output snp_cmd_e          lat_cmd,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data,
  output logic              lat_upd
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_m1;
  snp_cmd_e         cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic             upd_q;

  assign len_m1 = (cmd_q == CMD_WRITE) ? CNT_W'(WR_CYC - 1) : CNT_W'(OT_CYC - 1);
  assign accept = start & ~busy_q;
  assign last   = busy_q & (cnt_q == len_m1);

  // next-state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= CMD_NOP;
      upd_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (accept) begin
        cmd_q <= cmd;
        upd_q <= cfg_upd;
      end
    end
  end

  // payload capture, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  assign busy     = busy_q;
  assign phase    = cnt_q;
  assign lat_cmd  = cmd_q;
  assign lat_addr = addr_q;
  assign lat_data = data_q;
  assign lat_upd  = upd_q;

  // R1: the final bus cycle always returns the sequencer to idle
  a_r1_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);

  // R11: a start during a running transaction leaves the captured command intact
  a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> ($stable(cmd_q) && $stable(upd_q)));

endmodule

// File: rtl/snoop_probe.sv
module snoop_probe
  import snoop_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 21,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  snp_cmd_e         start_cmd,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             busy,
  input  logic [CNT_W-1:0] phase,
  input  snp_cmd_e         lat_cmd,
  input  logic [TAG_W-1:0] lat_tag,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_valid,
  input  logic             rd_dirty,
  output logic             tag_rd_en,
  output logic [IDX_W-1:0] tag_rd_idx,
  output logic             dec_fire,
  output logic             dec_hit,
  output logic             dec_dirty
);

  logic probe_slot;
  logic hit_now;
  logic fire_q, fire_d;
  logic hit_q, hit_d;
  logic dirty_q, dirty_d;

  // lookup issued in the start cycle
  assign tag_rd_en  = accept & needs_probe(start_cmd);
  assign tag_rd_idx = start_idx;

  // store data is present in bus cycle index 1
  assign probe_slot = busy & (phase == CNT_W'(1)) & needs_probe(lat_cmd);
  assign hit_now    = rd_valid & (rd_tag == lat_tag);

  always_comb begin
    fire_d  = probe_slot;
    hit_d   = hit_q;
    dirty_d = dirty_q;
    if (probe_slot) begin
      hit_d   = hit_now;
      dirty_d = rd_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q  <= 1'b0;
      hit_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      fire_q  <= fire_d;
      hit_q   <= hit_d;
      dirty_q <= dirty_d;
    end
  end

  assign dec_fire  = fire_q;
  assign dec_hit   = hit_q;
  assign dec_dirty = dirty_q;

  // R3: a decision is only ever presented two cycles after its lookup
  a_r3_decide_slot: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |-> $past(tag_rd_en, 2));

  // R10: a no-op never reaches the decision stage
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |-> (lat_cmd != CMD_NOP));

endmodule

// File: rtl/snoop_act.sv
module snoop_act
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_fire,
  input  logic              dec_hit,
  input  logic              dec_dirty,
  input  snp_cmd_e          lat_cmd,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_data,
  input  logic              lat_upd,
  input  logic              last,
  output logic              supply_req,
  output logic [IDX_W-1:0]  supply_idx,
  output logic              line_upd_en,
  output logic [ADDR_W-1:0] line_upd_addr,
  output logic [DATA_W-1:0] line_upd_data,
  output logic              tag_wr_en,
  output logic [IDX_W-1:0]  tag_wr_idx,
  output logic              tag_wr_valid,
  output logic              tag_wr_dirty,
  output logic              tag_wr_shared,
  output logic              bus_shared
);

  logic             wr_hit;
  logic             upd_fire;
  logic             inv_fire;
  logic             shared_q, shared_d;
  logic [IDX_W-1:0] line_idx;

  assign line_idx = lat_addr[OFF_W +: IDX_W];
  assign wr_hit   = dec_fire & dec_hit & (lat_cmd == CMD_WRITE);
  assign upd_fire = wr_hit & lat_upd;
  assign inv_fire = wr_hit & ~lat_upd;

  // dirty hit on read or exchange: cache answers instead of memory
  assign supply_req = dec_fire & dec_hit & dec_dirty & may_supply(lat_cmd);
  assign supply_idx = line_idx;

  assign line_upd_en   = upd_fire;
  assign line_upd_addr = lat_addr;
  assign line_upd_data = lat_data;

  // invalidate clears every state bit; update leaves the store alone
  assign tag_wr_en     = inv_fire;
  assign tag_wr_idx    = line_idx;
  assign tag_wr_valid  = 1'b0;
  assign tag_wr_dirty  = 1'b0;
  assign tag_wr_shared = 1'b0;

  always_comb begin
    shared_d = shared_q;
    if (upd_fire) begin
      shared_d = 1'b1;
    end else if (last) begin
      shared_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q <= 1'b0;
    end else begin
      shared_q <= shared_d;
    end
  end

  assign bus_shared = shared_q | upd_fire;

  // R7: once raised, SHARED holds until the final bus cycle
  a_r7_shared_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_shared && !last) |=> bus_shared);

  // R8: an invalidating write never coincides with SHARED
  a_r8_inval_no_shared: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_en |-> !bus_shared);

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 64,
  parameter int unsigned LINE_BYTES   = 32,
  parameter int unsigned NUM_SETS     = 64,
  parameter int unsigned WR_CYCLES    = WRITE_CYCLES_DEF,
  parameter int unsigned OTHER_CYCLES = OTHER_CYCLES_DEF,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W = $clog2(NUM_SETS),
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_start,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  input  logic              cfg_wr_update,
  output logic              tag_rd_en,
  output logic [IDX_W-1:0]  tag_rd_idx,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  input  logic              tag_rd_valid,
  input  logic              tag_rd_dirty,
  output logic              tag_wr_en,
  output logic [IDX_W-1:0]  tag_wr_idx,
  output logic              tag_wr_valid,
  output logic              tag_wr_dirty,
  output logic              tag_wr_shared,
  output logic              line_upd_en,
  output logic [ADDR_W-1:0] line_upd_addr,
  output logic [DATA_W-1:0] line_upd_data,
  output logic              supply_req,
  output logic [IDX_W-1:0]  supply_idx,
  output logic              bus_shared
);

  localparam int unsigned MAX_CYC = (WR_CYCLES > OTHER_CYCLES) ? WR_CYCLES : OTHER_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC);

  snp_cmd_e          in_cmd;
  logic              accept;
  logic              busy;
  logic [CNT_W-1:0]  phase;
  logic              last;
  snp_cmd_e          lat_cmd;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic              lat_upd;
  logic              dec_fire, dec_hit, dec_dirty;

  assign in_cmd = snp_cmd_e'(snp_cmd);

  snoop_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WR_CYC (WR_CYCLES),
    .OT_CYC (OTHER_CYCLES),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (snp_start),
    .cmd      (in_cmd),
    .addr     (snp_addr),
    .wdata    (snp_wdata),
    .cfg_upd  (cfg_wr_update),
    .accept   (accept),
    .busy     (busy),
    .phase    (phase),
    .last     (last),
    .lat_cmd  (lat_cmd),
    .lat_addr (lat_addr),
    .lat_data (lat_data),
    .lat_upd  (lat_upd)
  );

  snoop_probe #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
  ) u_probe (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .start_cmd  (in_cmd),
    .start_idx  (snp_addr[OFF_W +: IDX_W]),
    .busy       (busy),
    .phase      (phase),
    .lat_cmd    (lat_cmd),
    .lat_tag    (lat_addr[ADDR_W-1 -: TAG_W]),
    .rd_tag     (tag_rd_tag),
    .rd_valid   (tag_rd_valid),
    .rd_dirty   (tag_rd_dirty),
    .tag_rd_en  (tag_rd_en),
    .tag_rd_idx (tag_rd_idx),
    .dec_fire   (dec_fire),
    .dec_hit    (dec_hit),
    .dec_dirty  (dec_dirty)
  );

  snoop_act #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) u_act (
    .clk           (clk),
    .rst_n         (rst_n),
    .dec_fire      (dec_fire),
    .dec_hit       (dec_hit),
    .dec_dirty     (dec_dirty),
    .lat_cmd       (lat_cmd),
    .lat_addr      (lat_addr),
    .lat_data      (lat_data),
    .lat_upd       (lat_upd),
    .last          (last),
    .supply_req    (supply_req),
    .supply_idx    (supply_idx),
    .line_upd_en   (line_upd_en),
    .line_upd_addr (line_upd_addr),
    .line_upd_data (line_upd_data),
    .tag_wr_en     (tag_wr_en),
    .tag_wr_idx    (tag_wr_idx),
    .tag_wr_valid  (tag_wr_valid),
    .tag_wr_dirty  (tag_wr_dirty),
    .tag_wr_shared (tag_wr_shared),
    .bus_shared    (bus_shared)
  );

  // R4: data is only supplied for a line the store reported valid and dirty
  a_r4_supply_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    supply_req |-> $past(tag_rd_valid && tag_rd_dirty));

  // R6: the update carries the write data seen in the start cycle
  a_r6_upd_data: assert property (@(posedge clk) disable iff (!rst_n)
    line_upd_en |-> (line_upd_data == $past(snp_wdata, 2)));

  // R9: update/invalidate follows the mode input of the start cycle
  a_r9_mode_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (line_upd_en |-> $past(cfg_wr_update, 2)) and (tag_wr_en |-> !$past(cfg_wr_update, 2)));

endmodule

// File: tb/snoop_responder_test.sv
module snoop_responder_test;

  localparam int IDX_W = 6;
  localparam int TAG_W = 21;
  localparam int NSETS = 64;

  typedef struct {
    int          sup_at;
    int          upd_at;
    int          inv_at;
    int          sh_cnt;
    int          rd_cnt;
    int          len;
    int          idx;
    logic [31:0] addr;
    logic [63:0] data;
  } exp_t;

  logic clk, rst_n;
  logic snp_start;
  logic [1:0] snp_cmd;
  logic [31:0] snp_addr;
  logic [63:0] snp_wdata;
  logic cfg_wr_update;
  logic tag_rd_en;
  logic [IDX_W-1:0] tag_rd_idx;
  logic [TAG_W-1:0] tag_rd_tag;
  logic tag_rd_valid, tag_rd_dirty;
  logic tag_wr_en;
  logic [IDX_W-1:0] tag_wr_idx;
  logic tag_wr_valid, tag_wr_dirty, tag_wr_shared;
  logic line_upd_en;
  logic [31:0] line_upd_addr;
  logic [63:0] line_upd_data;
  logic supply_req;
  logic [IDX_W-1:0] supply_idx;
  logic bus_shared;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t q[$];

  snoop_responder uut (
    .clk(clk), .rst_n(rst_n), .snp_start(snp_start), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_wdata(snp_wdata), .cfg_wr_update(cfg_wr_update),
    .tag_rd_en(tag_rd_en), .tag_rd_idx(tag_rd_idx), .tag_rd_tag(tag_rd_tag),
    .tag_rd_valid(tag_rd_valid), .tag_rd_dirty(tag_rd_dirty),
    .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx), .tag_wr_valid(tag_wr_valid),
    .tag_wr_dirty(tag_wr_dirty), .tag_wr_shared(tag_wr_shared),
    .line_upd_en(line_upd_en), .line_upd_addr(line_upd_addr), .line_upd_data(line_upd_data),
    .supply_req(supply_req), .supply_idx(supply_idx), .bus_shared(bus_shared)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // tag store model: one-cycle read latency
  logic [TAG_W-1:0] st_tag [NSETS];
  logic             st_v   [NSETS];
  logic             st_d   [NSETS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) begin
        st_tag[i] <= '0; st_v[i] <= 1'b0; st_d[i] <= 1'b0;
      end
      st_tag[3] <= 21'h1A5; st_v[3] <= 1'b1; st_d[3] <= 1'b1;
      st_tag[5] <= 21'h0B0; st_v[5] <= 1'b1; st_d[5] <= 1'b0;
      st_tag[7] <= 21'h777; st_v[7] <= 1'b1; st_d[7] <= 1'b1;
      tag_rd_tag <= '0; tag_rd_valid <= 1'b0; tag_rd_dirty <= 1'b0;
    end else begin
      if (tag_rd_en) begin
        tag_rd_tag   <= st_tag[tag_rd_idx];
        tag_rd_valid <= st_v[tag_rd_idx];
        tag_rd_dirty <= st_d[tag_rd_idx];
      end
      if (tag_wr_en) begin
        st_v[tag_wr_idx] <= tag_wr_valid;
        st_d[tag_wr_idx] <= tag_wr_dirty;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [20:0] t, input logic [5:0] s);
    return {t, s, 5'd0};
  endfunction

  // driver: one full transaction, pushes its expected outcome
  task automatic txn(input logic [1:0] c, input logic [31:0] a, input logic [63:0] d,
                     input logic mode, input bit flip, input bit intrude);
    exp_t e;
    int   s;
    logic hit;
    int   len;
    len = (c == 2'b10) ? 6 : 7;
    @(posedge clk); #1;
    s   = int'(a[10:5]);
    hit = st_v[s] && (st_tag[s] == a[31:11]);
    e.sup_at = -1; e.upd_at = -1; e.inv_at = -1; e.sh_cnt = 0;
    e.rd_cnt = (c != 2'b00) ? 1 : 0;
    e.len = len; e.idx = s; e.addr = a; e.data = d;
    if (c == 2'b10 && hit) begin
      if (mode) begin e.upd_at = 2; e.sh_cnt = len - 2; end
      else e.inv_at = 2;
    end
    if ((c == 2'b01 || c == 2'b11) && hit && st_d[s]) e.sup_at = 2;
    q.push_back(e);
    snp_start = 1'b1; snp_cmd = c; snp_addr = a; snp_wdata = d; cfg_wr_update = mode;
    @(posedge clk); #1;
    snp_start = 1'b0;
    if (flip) cfg_wr_update = ~mode;
    for (int k = 2; k < len; k++) begin
      @(posedge clk); #1;
      if (intrude && k == 3) begin
        snp_start = 1'b1; snp_cmd = 2'b10; snp_wdata = ~d;
      end else begin
        snp_start = 1'b0;
      end
    end
  endtask

  // monitor: observes one window per accepted start, then compares
  bit          active = 0;
  int          widx, wlen;
  int          o_sup, o_upd, o_inv, o_sh, o_rd, o_sidx, o_ridx;
  logic [31:0] o_uaddr;
  logic [63:0] o_udata;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!active && snp_start) begin
        active = 1; widx = 0; wlen = (snp_cmd == 2'b10) ? 6 : 7;
        o_sup = -1; o_upd = -1; o_inv = -1; o_sh = 0; o_rd = 0; o_sidx = -1; o_ridx = -1;
        o_uaddr = '0; o_udata = '0;
      end
      if (active) begin
        if (tag_rd_en) begin o_rd++; o_ridx = int'(tag_rd_idx); end
        if (supply_req) begin o_sup = widx; o_sidx = int'(supply_idx); end
        if (line_upd_en) begin o_upd = widx; o_uaddr = line_upd_addr; o_udata = line_upd_data; end
        if (tag_wr_en) begin
          o_inv = widx;
          chk(!tag_wr_valid && !tag_wr_dirty && !tag_wr_shared, "R8 cleared state bits",
              {61'd0, tag_wr_valid, tag_wr_dirty, tag_wr_shared}, 64'd0);
        end
        if (bus_shared) o_sh++;
        if (widx == wlen - 1) begin
          exp_t e;
          active = 0;
          if (q.size() == 0) begin
            chk(1'b0, "R1 unexpected transaction", 64'd1, 64'd0);
          end else begin
            e = q.pop_front();
            chk(wlen == e.len, "R1 transaction length", 64'(wlen), 64'(e.len));
            chk(o_rd == e.rd_cnt, "R2/R10/R11 probe count", 64'(o_rd), 64'(e.rd_cnt));
            if (e.rd_cnt > 0)
              chk(o_ridx == e.idx, "R2 probe index", 64'(o_ridx), 64'(e.idx));
            chk(o_sup == e.sup_at, "R4/R5/R3 supply cycle", 64'(o_sup), 64'(e.sup_at));
            if (e.sup_at >= 0)
              chk(o_sidx == e.idx, "R4 supply index", 64'(o_sidx), 64'(e.idx));
            chk(o_upd == e.upd_at, "R6/R9 update cycle", 64'(o_upd), 64'(e.upd_at));
            if (e.upd_at >= 0) begin
              chk(o_udata == e.data, "R6 update data", o_udata, e.data);
              chk(o_uaddr == e.addr, "R6 update address", 64'(o_uaddr), 64'(e.addr));
            end
            chk(o_inv == e.inv_at, "R8/R9 invalidate cycle", 64'(o_inv), 64'(e.inv_at));
            chk(o_sh == e.sh_cnt, "R7 shared cycles", 64'(o_sh), 64'(e.sh_cnt));
          end
        end else begin
          widx++;
        end
      end else begin
        if (supply_req || line_upd_en || tag_wr_en || bus_shared || tag_rd_en)
          chk(1'b0, "R5/R10/R7 activity outside a transaction",
              {59'd0, tag_rd_en, supply_req, line_upd_en, tag_wr_en, bus_shared}, 64'd0);
      end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; snp_start = 1'b0; snp_cmd = 2'b00; snp_addr = '0;
    snp_wdata = '0; cfg_wr_update = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: quiet after reset
    chk(!tag_rd_en && !tag_wr_en && !line_upd_en && !supply_req && !bus_shared,
        "R12 reset outputs",
        {59'd0, tag_rd_en, tag_wr_en, line_upd_en, supply_req, bus_shared}, 64'd0);

    txn(2'b01, mk(21'h1A5, 3), 64'h0, 1'b0, 0, 0);               // R4 read dirty hit
    txn(2'b01, mk(21'h0B0, 5), 64'h0, 1'b0, 0, 0);               // R5 read clean hit
    txn(2'b01, mk(21'h123, 3), 64'h0, 1'b0, 0, 0);               // R5 read miss
    txn(2'b11, mk(21'h777, 7), 64'h0, 1'b0, 0, 0);               // R4 exchange dirty hit
    txn(2'b11, mk(21'h0B0, 5), 64'h0, 1'b0, 0, 0);               // R5 exchange clean hit
    txn(2'b00, mk(21'h1A5, 3), 64'h0, 1'b1, 0, 0);               // R10 no-op
    txn(2'b10, mk(21'h1A5, 3), 64'hDEAD_BEEF_0123_4567, 1'b1, 1, 0); // R6 R7 R9 update
    txn(2'b01, mk(21'h1A5, 3), 64'h0, 1'b0, 0, 0);               // R6 state kept: still dirty
    txn(2'b10, mk(21'h777, 7), 64'h55AA_55AA_55AA_55AA, 1'b0, 1, 0); // R8 R9 invalidate
    txn(2'b01, mk(21'h777, 7), 64'h0, 1'b0, 0, 0);               // R8 now a miss
    txn(2'b10, mk(21'h0AA, 9), 64'h1111_2222_3333_4444, 1'b1, 0, 0); // R5 write miss
    txn(2'b10, mk(21'h0B0, 5), 64'hCAFE_F00D_8765_4321, 1'b1, 0, 1); // R11 stray start
    repeat (3) @(posedge clk);
    txn(2'b10, mk(21'h0B0, 5), 64'h9999_8888_7777_6666, 1'b0, 0, 0); // R8 after a gap
    txn(2'b11, mk(21'h0B0, 5), 64'h0, 1'b0, 0, 0);               // R8 line gone
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R1 all transactions observed", 64'(q.size()), 64'd0);
    done = 1;
    report();
  end

endmodule